// File: doc/BRIEF.md
# Memory-Backed Fixed Delay Line

This block delays a stream of samples by a fixed number of clock cycles. Instead of moving every sample through a chain of registers on each edge, it stores samples in place in a two-port storage array. It moves two address counters past them. The write counter stores the newest sample every cycle. The read counter fetches the oldest one, and a final output register presents it. Apart from that one fetch register and the output register, the register cost is two small counters, however deep the delay.

Both counters step by one on every clock edge and wrap at the end of the array. After reset the read counter starts at the first entry and the write counter at the last entry. The two always point at different entries. With a synchronous array read plus the output register, a sample taken on an edge appears at the output exactly `DEPTH` edges later. Until `DEPTH` samples have passed through after reset, the output carries stale array contents and has no defined meaning. The only exception is the reset value described below.

Top module: `shift_ram_delay`

## Requirements
- R1: While `rst` is high, and for the first clock edge after it falls, `dout` is all zeros.
- R2: On a reset edge the read address becomes 0 and the write address becomes `DEPTH-1`.
- R3: When not in reset, each address counter advances by exactly one on every clock edge and wraps from `DEPTH-1` to 0.
- R4: The write address never equals the read address; it is always `DEPTH-1` ahead of it, modulo `DEPTH`.
- R5: For every edge `e` counted from the first edge with `rst` low (e = 0), the value of `dout` after edge `e+DEPTH` equals `din` sampled at edge `e`. This holds over many wraps of the array.
- R6: All `WIDTH` bits pass through unchanged, including all-ones, all-zeros and alternating-bit samples.
- R7: A reset in the middle of a stream restarts the delay. The first defined output after reset is the first sample taken after reset, and no earlier sample reappears at that time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1     | Clock, rising edge active |
| rst  | input  | 1     | Synchronous reset, active high |
| din  | input  | WIDTH | Sample taken on every clock edge |
| dout | output | WIDTH | Sample taken `DEPTH` edges earlier |

## Verification
The hardest case to reach from the ports is a reset in the middle of a stream. After such a reset the array still holds old samples at exactly the addresses the read counter will visit first. A wrong restart value would therefore produce a plausible but stale output. The bench fills the array with one recognisable ramp and resets while it is running. It then streams a second ramp drawn from a disjoint value range, so any sample left over from before the reset shows up as a mismatch. Long streams of pseudo-random and alternating-bit data wrap the counters several times to cover the wrap-around edge.

// File: rtl/shift_ram_pkg.sv
package shift_ram_pkg;
    localparam int DEF_DEPTH = 16;
    localparam int DEF_WIDTH = 8;

    function automatic bit is_pow2(input int n);
        return (n >= 2) && ((n & (n - 1)) == 0);
    endfunction

    function automatic int addr_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/shift_ram_ptr.sv
module shift_ram_ptr
    import shift_ram_pkg::*;
#(
    parameter int AW    = 4,
    parameter int START = 0
) (
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] addr
);
    typedef logic [AW-1:0] addr_t;
    localparam addr_t START_A = addr_t'(START);
    localparam addr_t LAST_A  = '1;

    addr_t nxt;

    always_comb begin
        if (addr == LAST_A) nxt = '0;
        else                nxt = addr + addr_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) addr <= START_A;
        else     addr <= nxt;
    end

    // R2
    start_val_chk: assert property (@(posedge clk) rst |=> addr == START_A);

    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> addr == addr_t'($past(addr) + addr_t'(1)));

    // R3
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == LAST_A) |=> addr == '0);
endmodule

// File: rtl/shift_ram_store.sv
module shift_ram_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) rd_data <= '0;
        else     rd_data <= cells[rd_addr];
    end

    // R4
    port_clash_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> wr_addr != rd_addr);
endmodule

// File: rtl/shift_ram_delay.sv
module shift_ram_delay
    import shift_ram_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH,
    parameter int WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int AW = addr_bits(DEPTH);
    typedef logic [AW-1:0] addr_t;

    typedef struct packed {
        addr_t            addr;
        logic [WIDTH-1:0] data;
    } wr_req_t;

    wr_req_t          wreq;
    addr_t            wr_addr;
    addr_t            rd_addr;
    logic [WIDTH-1:0] fetched;

    initial begin
        if (!is_pow2(DEPTH)) $error("DEPTH must be a power of two, at least 2");
    end

    shift_ram_ptr #(.AW(AW), .START(DEPTH - 1)) u_wr_ptr (
        .clk (clk),
        .rst (rst),
        .addr(wr_addr)
    );

    shift_ram_ptr #(.AW(AW), .START(0)) u_rd_ptr (
        .clk (clk),
        .rst (rst),
        .addr(rd_addr)
    );

    always_comb begin
        wreq.addr = wr_addr;
        wreq.data = din;
    end

    shift_ram_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (1'b1),
        .wr_addr(wreq.addr),
        .wr_data(wreq.data),
        .rd_addr(rd_addr),
        .rd_data(fetched)
    );

    always_ff @(posedge clk) begin
        if (rst) dout <= '0;
        else     dout <= fetched;
    end

    // R4
    lead_gap_chk: assert property (@(posedge clk) disable iff (rst)
        addr_t'(wr_addr - rd_addr) == addr_t'(DEPTH - 1));

    // R1
    out_clear_chk: assert property (@(posedge clk) rst |=> dout == '0);
endmodule

// File: tb/sim_shift_ram_delay.sv
module sim_shift_ram_delay;
    localparam int D = 16;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;

    logic [W-1:0] hist [4096];
    int cnt    = 0;
    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    shift_ram_delay #(.DEPTH(D), .WIDTH(W)) u0 (
        .clk (clk),
        .rst (rst),
        .din (din),
        .dout(dout)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (edge %0d)", req, act, exp, cnt);
        end
    endtask

    // Called just after a falling edge; cnt = non-reset edges seen so far.
    task automatic stream(input string req, input int mode, input int n, input int base);
        for (int i = 0; i < n; i++) begin
            logic [W-1:0] v;
            if (cnt == 1) check("R1", dout, '0);
            if (cnt - 1 >= D) check(req, dout, hist[(cnt - 1 - D) % 4096]);
            case (mode)
                0: v = W'(base + i);
                1: begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    v = lfsr[W-1:0];
                end
                default: case (i % 4)
                    0: v = '1;
                    1: v = '0;
                    2: v = {(W/2){2'b10}};
                    default: v = {(W/2){2'b01}};
                endcase
            endcase
            din = v;
            hist[cnt % 4096] = v;
            cnt++;
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1", dout, '0);
        rst = 1'b0;
        cnt = 0;
    endtask

    task automatic test_ramp();
        stream("R5", 0, 4 * D, 1);
    endtask

    task automatic test_random();
        stream("R5", 1, 6 * D, 0);
    endtask

    task automatic test_patterns();
        stream("R6", 2, 3 * D, 0);
    endtask

    task automatic test_restart();
        stream("R5", 0, D + D / 2, 8'h10);
        do_reset();
        stream("R7", 0, 3 * D, 8'hC0);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        test_ramp();
        test_random();
        test_patterns();
        test_restart();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule